// File: doc/BRIEF.md
# I2C Register-Pointer Target

This block is an I2C target that gives a bus host byte access to a 256-entry register file through an 8-bit internal pointer. SCL and SDA come in from open-drain pins. A two-flop synchroniser passes both lines into the system clock domain, and edge detection follows. The block drives SDA only through an active-high pull-low enable. It recognises start, repeated start and stop conditions, matches a fixed 7-bit device address, and acknowledges what it accepts.

A write transfer carries the pointer value in its first byte. Every further byte is stored at the pointer, after which the pointer advances. A write that holds only the pointer byte sets the position for a later read. A read transfer returns the byte at the pointer and advances the pointer after every byte, whether or not the host acknowledged it. A read with no offset written just before it therefore continues where the last read stopped, or at 00h after reset.

Control sits in one state machine with these states: IDLE, ADDR (address byte shifting), ADDR_ACK, OFFS (pointer byte), OFFS_ACK, WDATA (data byte in), WDATA_ACK, RDATA (data byte out), RDATA_ACK (host acknowledge bit) and WAIT (bus ignored). The transitions are as follows.
- A start goes from any state to ADDR.
- A stop goes from any state to IDLE.
- ADDR goes to ADDR_ACK on a match, or to WAIT on a mismatch.
- ADDR_ACK goes to OFFS for a write, or to RDATA for a read.
- OFFS goes to OFFS_ACK, then to WDATA.
- WDATA goes to WDATA_ACK, then back to WDATA.
- RDATA goes to RDATA_ACK.
- RDATA_ACK goes to RDATA on an acknowledge, or to WAIT on a not-acknowledge.

Top module: `i2c_regptr_target`

## Requirements
- R1: After reset, sda_oe is low, the pointer is 00h and every register reads as 00h, so a first read without an offset returns the contents of offset 00h.
- R2: A start is SDA falling while SCL is high, and a stop is SDA rising while SCL is high. Either one abandons a partly shifted byte, leaving the registers and the pointer as they were.
- R3: After a start, the block takes 7 address bits MSB-first, followed by a direction bit (0 = write, 1 = read). When the address matches DEV_ADDR, it pulls SDA low for the ninth clock.
- R4: On an address mismatch the block gives no acknowledge, leaves the pointer unchanged and ignores all clocks until the next start or stop.
- R5: In a write transfer, the first byte after the address is loaded into the pointer and acknowledged. A transfer holding only that byte followed by a stop sets the pointer for a later read.
- R6: Each further byte of a write transfer is stored at the pointer and acknowledged. The pointer then increments, wrapping from FFh to 00h.
- R7: In a read transfer, the block sends the byte at the pointer MSB-first. When the host answers a byte with an acknowledge (SDA low on the ninth clock), the next byte follows.
- R8: The pointer increments after every byte sent, whether it was acknowledged or not. A read that has no offset write before it resumes at the last read offset plus one.
- R9: After a not-acknowledge, the block releases SDA and ignores further clocks until a start or stop.
- R10: When an offset write is followed by a repeated start and a read address, the read begins at the offset just written.
- R11: sda_oe changes only while the synchronised SCL is low, except for the release forced by a start or stop.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_in | input | 1 | SCL pin level |
| sda_in | input | 1 | SDA pin level |
| sda_oe | output | 1 | High pulls SDA low |

## Verification
Write bursts that run from FEh past FFh show whether storage and pointer wrap across the top of the map. Offset-only writes, repeated-start reads and reads with no offset each take the pointer from a different source, and comparing them shows which source is used. Reads that end in a not-acknowledge, followed by a fresh read, show whether the pointer still advanced. Extra clocks sent after a not-acknowledge or a mismatched address, and a byte cut short by a stop, show that ignored traffic touches neither SDA nor the stored state.

// File: rtl/i2crp_pkg.sv
package i2crp_pkg;
    localparam int BYTE_W = 8;
    localparam int CNT_W  = 4;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_ADDR,
        ST_ADDR_ACK,
        ST_OFFS,
        ST_OFFS_ACK,
        ST_WDATA,
        ST_WDATA_ACK,
        ST_RDATA,
        ST_RDATA_ACK,
        ST_WAIT
    } tgt_state_e;
endpackage

// File: rtl/i2crp_sync.sv
module i2crp_sync #(
    parameter int W      = 2,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] chain [STAGES];

    genvar g;
    generate
        for (g = 0; g < STAGES; g++) begin : g_stage
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n)
                    chain[g] <= '1;
                else if (g == 0)
                    chain[g] <= d;
                else
                    chain[g] <= chain[(g == 0) ? 0 : g-1];
            end
        end
    endgenerate

    assign q = chain[STAGES-1];
endmodule

// File: rtl/i2crp_cond.sv
module i2crp_cond (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_s,
    input  logic sda_s,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_det,
    output logic stop_det
);
    logic scl_q;
    logic sda_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            scl_q <= 1'b1;
            sda_q <= 1'b1;
        end else begin
            scl_q <= scl_s;
            sda_q <= sda_s;
        end
    end

    assign scl_rise  = scl_s & ~scl_q;
    assign scl_fall  = ~scl_s & scl_q;
    assign start_det = scl_s & scl_q & sda_q & ~sda_s;
    assign stop_det  = scl_s & scl_q & ~sda_q & sda_s;
endmodule

// File: rtl/i2crp_regfile.sv
module i2crp_regfile #(
    parameter int AW = 8,
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [DW-1:0] wdata,
    input  logic [AW-1:0] raddr,
    output logic [DW-1:0] rdata
);
    localparam int DEPTH = 1 << AW;

    logic [DW-1:0] mem [DEPTH];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
        end else if (we) begin
            mem[waddr] <= wdata;
        end
    end

    assign rdata = mem[raddr];
endmodule

// File: rtl/i2c_regptr_target.sv
module i2c_regptr_target
    import i2crp_pkg::*;
#(
    parameter logic [6:0] DEV_ADDR    = 7'h3A,
    parameter int         PTR_W       = 8,
    parameter int         SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_in,
    input  logic sda_in,
    output logic sda_oe
);
    localparam logic [CNT_W-1:0] FULL = CNT_W'(BYTE_W);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(BYTE_W - 1);

    logic              scl_s, sda_s;
    logic              scl_rise, scl_fall, start_det, stop_det;
    tgt_state_e        state, state_n;
    logic [CNT_W-1:0]  bit_cnt;
    logic [BYTE_W-1:0] sh, tx;
    logic [PTR_W-1:0]  ptr;
    logic [BYTE_W-1:0] rd_data;
    logic              rw_q, got_ack, wr_en, rx_state;

    i2crp_sync #(.W(2), .STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst_n(rst_n),
        .d({scl_in, sda_in}), .q({scl_s, sda_s})
    );

    i2crp_cond u_cond (
        .clk(clk), .rst_n(rst_n), .scl_s(scl_s), .sda_s(sda_s),
        .scl_rise(scl_rise), .scl_fall(scl_fall),
        .start_det(start_det), .stop_det(stop_det)
    );

    i2crp_regfile #(.AW(PTR_W), .DW(BYTE_W)) u_regs (
        .clk(clk), .rst_n(rst_n), .we(wr_en), .waddr(ptr),
        .wdata(sh), .raddr(ptr), .rdata(rd_data)
    );

    // next-state decision
    always_comb begin
        state_n = state;
        unique case (state)
            ST_IDLE:      state_n = ST_IDLE;
            ST_ADDR:      if (scl_fall && bit_cnt == FULL)
                              state_n = (sh[7:1] == DEV_ADDR) ? ST_ADDR_ACK : ST_WAIT;
            ST_ADDR_ACK:  if (scl_fall) state_n = rw_q ? ST_RDATA : ST_OFFS;
            ST_OFFS:      if (scl_fall && bit_cnt == FULL) state_n = ST_OFFS_ACK;
            ST_OFFS_ACK:  if (scl_fall) state_n = ST_WDATA;
            ST_WDATA:     if (scl_fall && bit_cnt == FULL) state_n = ST_WDATA_ACK;
            ST_WDATA_ACK: if (scl_fall) state_n = ST_WDATA;
            ST_RDATA:     if (scl_fall && bit_cnt == LAST) state_n = ST_RDATA_ACK;
            ST_RDATA_ACK: if (scl_fall) state_n = got_ack ? ST_RDATA : ST_WAIT;
            ST_WAIT:      state_n = ST_WAIT;
            default:      state_n = ST_IDLE;
        endcase
        if (start_det)     state_n = ST_ADDR;
        else if (stop_det) state_n = ST_IDLE;
    end

    assign rx_state = (state == ST_ADDR) || (state == ST_OFFS) || (state == ST_WDATA);
    assign wr_en    = (state == ST_WDATA) && (state_n == ST_WDATA_ACK);

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_n;
    end

    // outputs and datapath
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bit_cnt <= '0;
            sh      <= '0;
            tx      <= '0;
            ptr     <= '0;
            rw_q    <= 1'b0;
            got_ack <= 1'b0;
            sda_oe  <= 1'b0;
        end else if (start_det || stop_det) begin
            bit_cnt <= '0;
            sda_oe  <= 1'b0;
        end else begin
            if (rx_state && scl_rise && bit_cnt != FULL) begin
                sh      <= {sh[BYTE_W-2:0], sda_s};
                bit_cnt <= bit_cnt + 1'b1;
            end
            unique case (state)
                ST_ADDR: if (state_n == ST_ADDR_ACK) begin
                    rw_q   <= sh[0];
                    sda_oe <= 1'b1;
                end
                ST_OFFS: if (state_n == ST_OFFS_ACK) begin
                    ptr    <= sh;
                    sda_oe <= 1'b1;
                end
                ST_WDATA: if (state_n == ST_WDATA_ACK) begin
                    ptr    <= ptr + 1'b1;
                    sda_oe <= 1'b1;
                end
                ST_ADDR_ACK, ST_OFFS_ACK, ST_WDATA_ACK: if (scl_fall) begin
                    bit_cnt <= '0;
                    if (state_n == ST_RDATA) begin
                        tx     <= rd_data;
                        sda_oe <= ~rd_data[BYTE_W-1];
                    end else begin
                        sda_oe <= 1'b0;
                    end
                end
                ST_RDATA: if (scl_fall) begin
                    if (bit_cnt == LAST) begin
                        sda_oe <= 1'b0;
                        ptr    <= ptr + 1'b1;
                    end else begin
                        tx      <= {tx[BYTE_W-2:0], 1'b0};
                        sda_oe  <= ~tx[BYTE_W-2];
                        bit_cnt <= bit_cnt + 1'b1;
                    end
                end
                ST_RDATA_ACK: begin
                    if (scl_rise) got_ack <= ~sda_s;
                    if (scl_fall) begin
                        bit_cnt <= '0;
                        if (state_n == ST_RDATA) begin
                            tx     <= rd_data;
                            sda_oe <= ~rd_data[BYTE_W-1];
                        end else begin
                            sda_oe <= 1'b0;
                        end
                    end
                end
                default: ;
            endcase
        end
    end
endmodule

// File: rtl/i2crp_checker.sv
module i2crp_checker
    import i2crp_pkg::*;
#(
    parameter int PTR_W = 8
) (
    input logic             clk,
    input logic             rst_n,
    input tgt_state_e       state,
    input logic [PTR_W-1:0] ptr,
    input logic             sda_oe,
    input logic             scl_s,
    input logic             start_det,
    input logic             stop_det
);
    // R11: SDA drive changes only while SCL low, or on a start/stop release
    p_oe_scl_low_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (sda_oe != $past(sda_oe)) |-> (!$past(scl_s) || $past(start_det) || $past(stop_det)));

    // R3 / R5: acknowledge is held during the address and offset ack slots
    p_ack_held_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_ADDR_ACK || state == ST_OFFS_ACK) |-> sda_oe);

    // R4 / R9: bus-ignore state never pulls SDA
    p_wait_released_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_WAIT) |-> !sda_oe);

    // R2: a stop returns to idle with SDA released
    p_stop_idle_r2: assert property (@(posedge clk) disable iff (!rst_n)
        stop_det |=> (state == ST_IDLE && !sda_oe));

    // R8: pointer moves by one step or by an offset load only
    p_ptr_step_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (ptr != $past(ptr)) |-> (ptr == $past(ptr) + 1'b1 || $past(state) == ST_OFFS));

    // R2: start and stop never flagged together
    p_cond_excl_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({start_det, stop_det}));
endmodule

bind i2c_regptr_target i2crp_checker #(.PTR_W(PTR_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .state(state), .ptr(ptr), .sda_oe(sda_oe),
    .scl_s(scl_s), .start_det(start_det), .stop_det(stop_det)
);

// File: tb/sim_i2c_regptr_target.sv
`timescale 1ns/1ps
module sim_i2c_regptr_target;
    localparam logic [6:0] DA = 7'h3A;
    localparam logic [6:0] XA = 7'h13;
    localparam int Q = 6;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic scl_h = 1'b1;
    logic sda_h = 1'b1;
    logic sda_oe;
    logic sda_line;
    int   nchk = 0;
    int   nfail = 0;
    int   cyc = 0;
    int   scl_hi_cnt = 0;
    logic oe_prev = 1'b0;

    logic [7:0] mem_m [256];
    int         ptr_m = 0;

    always #2 clk = ~clk;

    assign sda_line = sda_h & ~sda_oe;

    i2c_regptr_target u0 (
        .clk(clk), .rst_n(rst_n), .scl_in(scl_h), .sda_in(sda_line), .sda_oe(sda_oe)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        nchk++;
        if (!ok) begin
            nfail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("%0d/%0d checks passed", nchk - nfail, nchk);
        $finish;
    endtask

    // per-clock reference: with SCL steadily high the drive must hold (R11)
    always @(negedge clk) begin
        cyc++;
        if (rst_n) begin
            if (scl_hi_cnt >= 4) chk(sda_oe == oe_prev, "R11 drive change with SCL high", sda_oe, oe_prev);
            scl_hi_cnt = scl_h ? scl_hi_cnt + 1 : 0;
            oe_prev = sda_oe;
        end
        if (cyc > 150000) begin
            chk(1'b0, "watchdog", cyc, 150000);
            finish_run();
        end
    end

    task automatic wq();
        repeat (Q) @(negedge clk);
    endtask

    task automatic bus_start();
        sda_h = 1'b1; wq(); scl_h = 1'b1; wq(); sda_h = 1'b0; wq(); scl_h = 1'b0; wq();
    endtask

    task automatic bus_stop();
        sda_h = 1'b0; wq(); scl_h = 1'b1; wq(); sda_h = 1'b1; wq();
    endtask

    task automatic bit_xfer(input logic b, output logic s);
        sda_h = b; wq(); scl_h = 1'b1; wq(); s = sda_line; wq(); scl_h = 1'b0; wq();
    endtask

    task automatic wr_byte(input logic [7:0] d, output logic ack_n);
        logic s;
        for (int i = 7; i >= 0; i--) bit_xfer(d[i], s);
        bit_xfer(1'b1, ack_n);
    endtask

    task automatic rd_byte(input logic nack, output logic [7:0] v);
        logic s;
        for (int i = 7; i >= 0; i--) begin
            bit_xfer(1'b1, s);
            v[i] = s;
        end
        bit_xfer(nack, s);
    endtask

    task automatic rd_expect(input logic nack, input string req);
        logic [7:0] v;
        rd_byte(nack, v);
        chk(v == mem_m[ptr_m], req, v, mem_m[ptr_m]);
        ptr_m = (ptr_m + 1) % 256;
    endtask

    task automatic wr_expect_ack(input logic [7:0] d, input string req);
        logic a;
        wr_byte(d, a);
        chk(a == 1'b0, req, a, 0);
    endtask

    initial begin
        logic a;
        logic [7:0] v;
        logic s;
        for (int i = 0; i < 256; i++) mem_m[i] = 8'h00;
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        repeat (5) @(negedge clk);

        // R1: reset state
        chk(sda_oe == 1'b0, "R1 sda_oe after reset", sda_oe, 0);

        // R4: foreign address gets no ACK, following clocks ignored
        bus_start();
        wr_byte({XA, 1'b0}, a);
        chk(a == 1'b1, "R4 no ack on mismatch", a, 1);
        wr_byte(8'h00, a);
        chk(a == 1'b1, "R4 bus ignored after mismatch", a, 1);
        bus_stop();

        // R1 / R7: first read after reset starts at 00h
        bus_start();
        wr_expect_ack({DA, 1'b1}, "R3 read address ack");
        rd_expect(1'b0, "R1 first read at 00h");
        rd_expect(1'b1, "R7 second read byte");
        bus_stop();

        // R5 / R6: write burst across the FFh wrap
        bus_start();
        wr_expect_ack({DA, 1'b0}, "R3 write address ack");
        wr_expect_ack(8'hFE, "R5 offset ack");
        ptr_m = 8'hFE;
        begin
            logic [7:0] dat [4] = '{8'h11, 8'h22, 8'h33, 8'h44};
            for (int i = 0; i < 4; i++) begin
                wr_expect_ack(dat[i], "R6 data ack");
                mem_m[ptr_m] = dat[i];
                ptr_m = (ptr_m + 1) % 256;
            end
        end
        bus_stop();

        // R5: offset-only write then plain read
        bus_start();
        wr_expect_ack({DA, 1'b0}, "R3 write address ack");
        wr_expect_ack(8'h00, "R5 offset-only ack");
        ptr_m = 0;
        bus_stop();
        bus_start();
        wr_expect_ack({DA, 1'b1}, "R3 read address ack");
        rd_expect(1'b1, "R5 read from offset-only pointer wrapped R6");
        // R9: clocks after NACK see a released line
        rd_byte(1'b1, v);
        chk(v == 8'hFF, "R9 SDA released after NACK", v, 8'hFF);
        bus_stop();

        // R8: NACKed byte still advanced the pointer
        bus_start();
        wr_expect_ack({DA, 1'b1}, "R3 read address ack");
        rd_expect(1'b1, "R8 resume at last plus one after NACK");
        bus_stop();

        // R10: repeated start read begins at just-written offset
        bus_start();
        wr_expect_ack({DA, 1'b0}, "R3 write address ack");
        wr_expect_ack(8'hFE, "R5 offset ack");
        ptr_m = 8'hFE;
        bus_start();
        wr_expect_ack({DA, 1'b1}, "R10 read address after Sr ack");
        rd_expect(1'b0, "R10 read at written offset");
        rd_expect(1'b0, "R7 ACK continues at FFh");
        rd_expect(1'b1, "R6 wrapped to 00h");
        bus_stop();

        // R4: mismatched read address leaves pointer untouched
        bus_start();
        wr_byte({XA, 1'b1}, a);
        chk(a == 1'b1, "R4 no ack on mismatched read", a, 1);
        bus_stop();
        bus_start();
        wr_expect_ack({DA, 1'b1}, "R3 read address ack");
        rd_expect(1'b1, "R4 pointer unchanged by mismatch R8");
        bus_stop();

        // R2: stop in the middle of a data byte aborts it
        bus_start();
        wr_expect_ack({DA, 1'b0}, "R3 write address ack");
        wr_expect_ack(8'h00, "R5 offset ack");
        ptr_m = 0;
        for (int i = 0; i < 4; i++) bit_xfer(1'b1, s);
        bus_stop();
        bus_start();
        wr_expect_ack({DA, 1'b1}, "R3 read address ack");
        rd_expect(1'b1, "R2 aborted byte not stored");
        bus_stop();

        // R2: start in the middle of an offset byte aborts it
        bus_start();
        wr_expect_ack({DA, 1'b0}, "R3 write address ack");
        for (int i = 0; i < 4; i++) bit_xfer(1'b0, s);
        bus_start();
        wr_expect_ack({DA, 1'b1}, "R2 address after abort ack");
        rd_expect(1'b1, "R2 partial offset left pointer");
        bus_stop();

        repeat (10) @(negedge clk);
        finish_run();
    end
endmodule